// File: doc/BRIEF.md
# Six-Step Serial Pattern Generator

This block emits a fixed serial bit pattern, 1,1,0,0,1,0, repeated without gaps for as long as it is enabled. It has two parts. The first is a 4-bit synchronous up-counter with a clear, a parallel load, two count enables and a terminal-carry output. The second is a pair of 8-to-1 lookup multiplexers, both selected by the counter's low three bits. One multiplexer returns the pattern bit for the current step. The other returns the counter's own active-low load strobe. That strobe drops in step 5, and the counter then reloads zero. The pattern length therefore comes from the lookup contents, and no extra decode gates are needed.

The output is a plain serial level with no handshake. The counter state and the carry are brought out as plain status pins. A system first holds `clr_n` low for at least one clock, and then drives the two enables to let the pattern advance.

Top module: `seq_pattern_gen`

## Requirements
- R1: After a clear, with `cnt_en_t` and `cnt_en_p` both held high, `ser_out` repeats 1,1,0,0,1,0 with a period of six clocks. The first bit is the one seen in the cycle after the clear.
- R2: `clr_n` low at a rising edge sets `count_q` to 0000 at that edge, whatever the enables and the current count.
- R3: With `clr_n` high and `count_q` in 0000..0100, `count_q` goes up by one at an edge when both enables are high. If either enable is low, `count_q` holds its value.
- R4: With `clr_n` high and `count_q` equal to 0101, the next edge loads 0000. This happens whatever the enables are, because the load takes priority over the count enables.
- R5: `ser_out` equals the pattern bit picked by `count_q[2:0]` in the same cycle: steps 0,1,2,3,4,5 give 1,1,0,0,1,0.
- R6: `carry_out` is high only when `count_q` is 1111 and `cnt_en_t` is high. Since 1111 cannot be reached from a clear, it stays low in use.
- R7: Once a clear has been seen, `count_q` never leaves the range 0000..0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| cnt_en_t | input | 1 | Count enable that also gates the carry |
| cnt_en_p | input | 1 | Second count enable |
| ser_out | output | 1 | Serial pattern bit |
| count_q | output | 4 | Current counter state |
| carry_out | output | 1 | Terminal-count carry |

## Verification
Every change to `count_q` shows up one edge after the inputs that caused it. `ser_out` follows `count_q` in the same cycle, with no extra register. `carry_out` is purely combinational from the count and `cnt_en_t`. The bench changes its inputs on the falling edge and advances a behavioural model on the rising edge. It then compares all three outputs against that model on the next falling edge, so each result is checked in the cycle where it is due. Random enable patterns make the model cover holds in every step as well as the forced reload out of step 5.

// File: rtl/seq_pattern_pkg.sv
package seq_pattern_pkg;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned PERIOD  = 6;
  // bit i is emitted in step i
  localparam logic [PERIOD-1:0] PATTERN = 6'b010011;
endpackage

// File: rtl/sync_load_counter.sv
module sync_load_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         ent,
  input  logic         enp,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!clr_n)          q <= '0;
    else if (!ld_n)      q <= din;
    else if (ent && enp) q <= q + 1'b1;
  end

  assign rco = ent && (q == ALL_ONES);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clr_n;

  // R2
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);
  // R4
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && !ld_n |=> q == $past(din));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && ld_n && !(ent && enp) |=> $stable(q));
  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && ld_n && ent && enp |=> q == $past(q) + 1'b1);
  // R6
  carry_only_full_chk: assert property (@(posedge clk) disable iff (!armed)
    rco |-> (q == ALL_ONES) && ent);
endmodule

// File: rtl/lookup_mux.sv
module lookup_mux #(
  parameter int unsigned SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] data,
  input  logic [SEL_W-1:0]      sel,
  output logic                  y
);
  always_comb y = data[sel];
endmodule

// File: rtl/seq_pattern_gen.sv
module seq_pattern_gen
  import seq_pattern_pkg::*;
(
  input  logic             clk,
  input  logic             clr_n,
  input  logic             cnt_en_t,
  input  logic             cnt_en_p,
  output logic             ser_out,
  output logic [CNT_W-1:0] count_q,
  output logic             carry_out
);
  localparam int unsigned MUX_N = 1 << SEL_W;
  localparam int unsigned LAST  = PERIOD - 1;

  logic [MUX_N-1:0] pat_vec;
  logic [MUX_N-1:0] ld_vec;
  logic             ld_n;

  // lookup contents: pattern bits, and a load strobe low only in the last step
  for (genvar i = 0; i < MUX_N; i++) begin : g_tbl
    if (i < PERIOD) begin : g_used
      assign pat_vec[i] = PATTERN[i];
    end else begin : g_unused
      assign pat_vec[i] = 1'b0;
    end
    assign ld_vec[i] = (i == LAST) ? 1'b0 : 1'b1;
  end

  sync_load_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .clr_n(clr_n),
    .ld_n (ld_n),
    .ent  (cnt_en_t),
    .enp  (cnt_en_p),
    .din  ('0),
    .q    (count_q),
    .rco  (carry_out)
  );

  lookup_mux #(.SEL_W(SEL_W)) u_pat_mux (
    .data(pat_vec),
    .sel (count_q[SEL_W-1:0]),
    .y   (ser_out)
  );

  lookup_mux #(.SEL_W(SEL_W)) u_ld_mux (
    .data(ld_vec),
    .sel (count_q[SEL_W-1:0]),
    .y   (ld_n)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clr_n;

  // R7
  count_in_range_chk: assert property (@(posedge clk) disable iff (!armed)
    count_q <= CNT_W'(LAST));
  // R4
  wrap_after_last_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && count_q == CNT_W'(LAST) |=> count_q == '0);
  // R1
  first_bit_one_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> ser_out == 1'b1);
endmodule

// File: tb/seq_pattern_gen_tb_top.sv
module seq_pattern_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       clr_n = 1'b1;
  logic       en_t = 1'b0;
  logic       en_p = 1'b0;
  logic       ser_out, carry_out;
  logic [3:0] count_q;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int model = -1;   // -1 = not yet cleared
  bit done = 1'b0;
  // steps 0..5 emit 1,1,0,0,1,0
  int pat[6] = '{1, 1, 0, 0, 1, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_pattern_gen dut_i (
    .clk(clk), .clr_n(clr_n), .cnt_en_t(en_t), .cnt_en_p(en_p),
    .ser_out(ser_out), .count_q(count_q), .carry_out(carry_out)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!clr_n)           model <= 0;           // R2
    else if (model == 5)  model <= 0;           // R4
    else if (model >= 0 && en_t && en_p) model <= model + 1; // R3
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (model >= 0 && !done) begin
      total++;
      if (int'(count_q) != model) begin
        bad++;
        $display("FAIL R2/R3/R4/R7 count: actual=%0d expected=%0d", count_q, model);
      end
      total++;
      if (int'(ser_out) != pat[model]) begin
        bad++;
        $display("FAIL R1/R5 ser_out in step %0d: actual=%0d expected=%0d",
                 model, ser_out, pat[model]);
      end
      total++;
      if (carry_out !== 1'b0) begin
        bad++;
        $display("FAIL R6 carry_out: actual=%0d expected=0", carry_out);
      end
    end
  end

  task automatic step(input bit c, input bit t, input bit p);
    @(negedge clk);
    clr_n = c; en_t = t; en_p = p;
  endtask

  initial begin
    // reset state
    step(0, 1, 1);
    step(1, 1, 1);
    total++;
    if (count_q !== 4'd0 || ser_out !== 1'b1) begin
      bad++;
      $display("FAIL R2 reset state: actual=%0d/%0d expected=0/1", count_q, ser_out);
    end
    // R1: free-running pattern over several periods
    for (int i = 0; i < 24; i++) step(1, 1, 1);
    // R3: hold with each enable low in turn
    for (int i = 0; i < 8; i++) step(1, i[0], ~i[0]);
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    // R4: reach step 5 then stop enables; wrap still happens
    while (model != 5) step(1, 1, 1);
    step(1, 0, 0);
    step(1, 0, 0);
    // R2: clear in mid-pattern and while in step 5
    for (int i = 0; i < 3; i++) step(1, 1, 1);
    step(0, 1, 1);
    while (model != 5) step(1, 1, 1);
    step(0, 0, 1);
    // random enables over many cycles (R3, R4, R7)
    for (int i = 0; i < 300; i++) begin
      automatic int r = $urandom_range(0, 15);
      step(r != 0, r[1] | r[2], r[0] | r[3]);
    end
    step(1, 1, 1);
    step(1, 1, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule